// File: doc/BRIEF.md
# Shared-Line Half-Duplex ADC Host

This block is the host side of a serial link to a 10-bit converter whose data input and data output are tied together into one bidirectional wire. The block runs a frame when it is asked to. It pulls chip select low and drives four command bits onto the shared line: a start bit of one, the mode bit, the channel bit and a don't-care padding bit. It generates the serial clock from the system clock. It hands the line over to the converter at a fixed point in the clock sequence. Then it shifts in the reply, which is one zero placeholder bit followed by the result, most significant bit first.

The handover is the critical moment. The converter samples the padding bit on the 4th rising serial edge and starts to drive the line low on the 4th falling edge. The host output enable must therefore drop strictly between those two edges. The block drops it exactly one system cycle after it makes the 4th rising edge. A separate input tells the block when the converter drives the line. If that input and the host output enable are active together, the block raises a contention flag.

The tri-state pad and the converter itself sit outside the block. The host output value and its enable go to a pad, and the resolved line returns on `line_in_i`.

Top module: `shline_adc_host`

## Requirements
- R1: While reset is asserted and after it is released, chip select is high, the serial clock is low, the output enable and the valid flag are low and the block is not busy.
- R2: A request in idle pulls chip select low on the next system edge. From that edge on, the output enable is high and the line carries the start bit (1), with the serial clock still low.
- R3: The four rising serial edges sample, in order: 1, the mode input (1 = single-ended, 0 = differential), the channel input (odd/sign) and 0. The host changes the line value only on falling serial edges.
- R4: The output enable is high in the system cycle after the 4th rising serial edge and low from the cycle after that, so it is low before the 4th falling edge.
- R5: Once released, the output enable stays low for the rest of the frame and until the next request is accepted.
- R6: The serial clock stays in each level for HALF_DIV system cycles. A frame has exactly 15 rising serial edges, and the clock is high for 14*HALF_DIV+1 system cycles in total.
- R7: The 5th rising edge samples the placeholder bit. Rising edges 6 to 15 shift in the result MSB first. `valid_o` is high for exactly one cycle with the received value on `result_o`.
- R8: Chip select rises on the same system edge as the 15th rising serial edge, together with `valid_o`. The serial clock returns low one cycle later.
- R9: `contention_o` is high in the cycle after any cycle in which the output enable and `dev_drive_i` are both high, and low otherwise. A correctly timed handover never raises it.
- R10: A request made during a frame is ignored. The frame continues unchanged and no new frame follows it.
- R11: All four combinations of the mode and channel inputs are sent as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Start a frame (taken in idle only) |
| single_i | input | 1 | Mode bit: 1 single-ended, 0 differential |
| odd_i | input | 1 | Channel / polarity bit |
| busy_o | output | 1 | Frame in progress |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| line_out_o | output | 1 | Value for the shared line |
| line_oe_o | output | 1 | Host drive enable for the shared line |
| line_in_i | input | 1 | Resolved shared line |
| dev_drive_i | input | 1 | Indication that the converter drives the line |
| result_o | output | RES_W | Last received result |
| valid_o | output | 1 | One-cycle result strobe |
| contention_o | output | 1 | Both sides drove the line in the previous cycle |

## Verification
The bench builds the block with HALF_DIV = 2, the smallest legal divider, and RES_W = 10. With HALF_DIV = 2, the release of the output enable and the converter's first drive are only one system cycle apart. An off-by-one in the release timing therefore appears at once, either as a late enable or as a contention pulse. The 10-bit width gives the exact 15-edge frame, so the bench can check that chip select rises on the last rising edge and that the result arrives MSB first.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } sdl_state_e;

  typedef struct packed {
    logic single;
    logic odd;
  } sdl_mux_t;

  localparam int unsigned SDL_CMD_BITS = 4;

endpackage

// File: rtl/sdl_sclk_gen.sv
module sdl_sclk_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_stb_o,
  output logic fall_stb_o
);

  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          terminal;

  assign terminal = (cnt_q == TERM);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (terminal) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o     = sclk_q;
  assign rise_stb_o = run_i && terminal && !sclk_q;
  assign fall_stb_o = run_i && terminal &&  sclk_q;

  // R6: the level only moves at the end of a half period
  a_r6_hold_between_toggles: assert property (
    @(posedge clk) disable iff (!rst_n)
    (run_i && !terminal) |=> (sclk_q == $past(sclk_q)));

endmodule

// File: rtl/sdl_frame_seq.sv
module sdl_frame_seq
  import sdl_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  localparam int unsigned LAST_RISE = SDL_CMD_BITS + 1 + RES_W,
  localparam int unsigned RCW = $clog2(LAST_RISE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_i,
  input  sdl_mux_t       mux_i,
  input  logic           rise_stb_i,
  input  logic           fall_stb_i,
  output sdl_state_e     state_o,
  output logic [RCW-1:0] rise_cnt_o,
  output logic           cs_n_o,
  output logic           run_o,
  output logic           line_out_o,
  output logic           line_oe_o,
  output logic           shift_en_o,
  output logic           clr_o
);

  localparam logic [RCW-1:0] REL_AT  = RCW'(SDL_CMD_BITS);
  localparam logic [RCW-1:0] DATA_AT = RCW'(SDL_CMD_BITS + 1);
  localparam logic [RCW-1:0] END_AT  = RCW'(LAST_RISE - 1);

  sdl_state_e              state_q, state_d;
  logic [RCW-1:0]          cnt_q, cnt_d;
  logic [SDL_CMD_BITS-1:0] cmd_q, cmd_d;
  logic                    oe_q, oe_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cmd_d   = cmd_q;
    oe_d    = oe_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_XFER;
          cnt_d   = '0;
          cmd_d   = {1'b1, mux_i.single, mux_i.odd, 1'b0};
          oe_d    = 1'b1;
        end
      end
      ST_XFER: begin
        if (oe_q && (cnt_q == REL_AT)) oe_d = 1'b0;
        if (fall_stb_i) cmd_d = {cmd_q[SDL_CMD_BITS-2:0], 1'b0};
        if (rise_stb_i) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == END_AT) state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        oe_d    = 1'b0;
      end
      default: begin
        state_d = ST_IDLE;
        oe_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      oe_q    <= oe_d;
    end
  end

  assign state_o    = state_q;
  assign rise_cnt_o = cnt_q;
  assign cs_n_o     = (state_q != ST_XFER);
  assign run_o      = (state_q == ST_XFER);
  assign line_oe_o  = oe_q;
  assign line_out_o = oe_q & cmd_q[SDL_CMD_BITS-1];
  assign shift_en_o = (state_q == ST_XFER) && rise_stb_i && (cnt_q >= DATA_AT);
  assign clr_o      = (state_q == ST_IDLE) && req_i;

  // R5: no drive once the turnaround edge has passed
  a_r5_oe_stays_low: assert property (
    @(posedge clk) disable iff (!rst_n)
    ((state_q == ST_XFER) && (cnt_q > REL_AT)) |-> !oe_q);

  // R10: a request inside a frame neither restarts nor rewinds it
  a_r10_req_no_restart: assert property (
    @(posedge clk) disable iff (!rst_n)
    ((state_q == ST_XFER) && req_i) |=> ((state_q != ST_IDLE) && (cnt_q >= $past(cnt_q))));

endmodule

// File: rtl/sdl_rx_shift.sv
module sdl_rx_shift #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clr_i)     sh_d = '0;
    else if (en_i) sh_d = {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign data_o = sh_q;

  // R7: each new bit enters at the low end, so the first one ends as MSB
  a_r7_shift_msb_first: assert property (
    @(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |=> (data_o[0] == $past(bit_i)));

endmodule

// File: rtl/sdl_contend_mon.sv
module sdl_contend_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_i,
  input  logic drive_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  always_comb flag_d = oe_i & drive_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/shline_adc_host.sv
module shline_adc_host
  import sdl_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned RES_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             single_i,
  input  logic             odd_i,
  output logic             busy_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             line_out_o,
  output logic             line_oe_o,
  input  logic             line_in_i,
  input  logic             dev_drive_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             contention_o
);

  localparam int unsigned LAST_RISE = SDL_CMD_BITS + 1 + RES_W;
  localparam int unsigned RCW       = $clog2(LAST_RISE + 1);
  localparam logic [RCW-1:0] REL_AT = RCW'(SDL_CMD_BITS);
  localparam logic [RCW-1:0] END_AT = RCW'(LAST_RISE - 1);

  // reset: asserted at once, released through two flops
  logic rst_s1_q, rst_s2_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n_s = rst_s2_q;

  sdl_state_e     state;
  logic [RCW-1:0] rise_cnt;
  logic           run, rise_stb, fall_stb, shift_en, clr;
  sdl_mux_t       mux;

  assign mux.single = single_i;
  assign mux.odd    = odd_i;

  sdl_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .run_i      (run),
    .sclk_o     (sclk_o),
    .rise_stb_o (rise_stb),
    .fall_stb_o (fall_stb)
  );

  sdl_frame_seq #(.RES_W(RES_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_i      (req_i),
    .mux_i      (mux),
    .rise_stb_i (rise_stb),
    .fall_stb_i (fall_stb),
    .state_o    (state),
    .rise_cnt_o (rise_cnt),
    .cs_n_o     (cs_n_o),
    .run_o      (run),
    .line_out_o (line_out_o),
    .line_oe_o  (line_oe_o),
    .shift_en_o (shift_en),
    .clr_o      (clr)
  );

  sdl_rx_shift #(.W(RES_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr_i  (clr),
    .en_i   (shift_en),
    .bit_i  (line_in_i),
    .data_o (result_o)
  );

  sdl_contend_mon u_mon (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .oe_i    (line_oe_o),
    .drive_i (dev_drive_i),
    .flag_o  (contention_o)
  );

  assign busy_o  = (state != ST_IDLE);
  assign valid_o = (state == ST_DONE);

  // R4: host is off the line before the converter's first drive edge
  a_r4_released_before_fall: assert property (
    @(posedge clk) disable iff (!rst_n_s)
    (fall_stb && (state == ST_XFER) && (rise_cnt >= REL_AT)) |-> !line_oe_o);

  // R3: line value is held across every rising serial edge
  a_r3_stable_on_rise: assert property (
    @(posedge clk) disable iff (!rst_n_s)
    (rise_stb && line_oe_o) |=> $stable(line_out_o));

  // R8: last rising edge and chip select release coincide
  a_r8_cs_with_last_rise: assert property (
    @(posedge clk) disable iff (!rst_n_s)
    ((state == ST_XFER) && rise_stb && (rise_cnt == END_AT)) |=> (cs_n_o && sclk_o && valid_o));

  // R7: result strobe lasts one cycle
  a_r7_valid_single: assert property (
    @(posedge clk) disable iff (!rst_n_s)
    valid_o |=> !valid_o);

  // R9: a flag always traces back to a host drive
  a_r9_flag_has_drive: assert property (
    @(posedge clk) disable iff (!rst_n_s)
    contention_o |-> $past(line_oe_o));

endmodule

// File: tb/sim_shline_adc_host.sv
module sim_shline_adc_host;

  localparam int H = 2;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0, single_i = 1'b0, odd_i = 1'b0;
  logic busy_o, cs_n_o, sclk_o, line_out_o, line_oe_o, valid_o, contention_o;
  logic line_in_i, dev_drive_i;
  logic [W-1:0] result_o;

  always #10 clk = ~clk;

  // converter model state
  logic         dev_drive = 1'b0, dev_bit = 1'b0, force_drive = 1'b0;
  logic [W-1:0] dev_val = '0;
  logic         prev_sclk = 1'b0;
  logic         line_w;
  int           rises, falls, high_cnt, cont_seen;
  logic [3:0]   cmd_seen;
  logic         oe_c0, oe_c1, oe_pend, oe_late, cs_at_last, valid_at_last;
  int           total = 0, bad = 0, cyc = 0;

  assign line_w      = dev_drive ? dev_bit : (line_oe_o ? line_out_o : 1'b1);
  assign line_in_i   = line_w;
  assign dev_drive_i = dev_drive | force_drive;

  shline_adc_host #(.HALF_DIV(H), .RES_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .single_i(single_i), .odd_i(odd_i),
    .busy_o(busy_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .line_out_o(line_out_o),
    .line_oe_o(line_oe_o), .line_in_i(line_in_i), .dev_drive_i(dev_drive_i),
    .result_o(result_o), .valid_o(valid_o), .contention_o(contention_o)
  );

  always @(negedge clk) begin
    if (sclk_o && !prev_sclk) begin
      rises = rises + 1;
      if (rises <= 4) cmd_seen[4-rises] = line_w;
      if (rises == 4) begin oe_c0 = line_oe_o; oe_pend = 1'b1; end
      if (rises == 15) begin cs_at_last = cs_n_o; valid_at_last = valid_o; end
    end else if (oe_pend) begin
      oe_c1 = line_oe_o; oe_pend = 1'b0;
    end
    if (rises >= 4 && line_oe_o && !(sclk_o && !prev_sclk && rises == 4)) oe_late = 1'b1;
    if (!sclk_o && prev_sclk && !cs_n_o) begin
      falls = falls + 1;
      if (falls >= 4) dev_drive = 1'b1;
      if (falls >= 5 && falls <= 14) dev_bit = dev_val[14-falls];
      else dev_bit = 1'b0;
    end
    if (cs_n_o) dev_drive = 1'b0;
    if (sclk_o) high_cnt = high_cnt + 1;
    if (contention_o) cont_seen = cont_seen + 1;
    prev_sclk = sclk_o;
  end

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises = 0; falls = 0; high_cnt = 0; cont_seen = 0; cmd_seen = '0;
    oe_c0 = 1'b0; oe_c1 = 1'b1; oe_pend = 1'b0; oe_late = 1'b0;
    cs_at_last = 1'b0; valid_at_last = 1'b0;
  endtask

  task automatic start_frame(input logic sgl, input logic odd, input logic [W-1:0] val);
    clear_mon();
    dev_val = val; single_i = sgl; odd_i = odd; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(cs_n_o == 1'b0 && line_oe_o && line_out_o && !sclk_o, "R2",
        {cs_n_o, line_oe_o, line_out_o, sclk_o}, 4'b0110);
  endtask

  task automatic finish_frame(input logic sgl, input logic odd, input logic [W-1:0] val,
                              input logic expect_cont);
    int n = 0;
    while (!valid_o && n < 400) begin @(negedge clk); n++; end
    chk(valid_o == 1'b1, "R7", valid_o, 1);
    chk(result_o == val, "R7", result_o, val);
    @(negedge clk);
    chk(valid_o == 1'b0 && sclk_o == 1'b0, "R8", {valid_o, sclk_o}, 0);
    chk(cmd_seen == {1'b1, sgl, odd, 1'b0}, "R11", cmd_seen, {1'b1, sgl, odd, 1'b0});
    chk(oe_c0 == 1'b1 && oe_c1 == 1'b0, "R4", {oe_c0, oe_c1}, 2);
    chk(!oe_late, "R5", oe_late, 0);
    chk(rises == 15, "R6", rises, 15);
    chk(high_cnt == 14*H + 1, "R6", high_cnt, 14*H + 1);
    chk(cs_at_last && valid_at_last, "R8", {cs_at_last, valid_at_last}, 3);
    if (!expect_cont) chk(cont_seen == 0, "R9", cont_seen, 0);
    repeat (3) @(negedge clk);
    chk(cs_n_o && !busy_o && !line_oe_o, "R5", {cs_n_o, busy_o, line_oe_o}, 4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n_o && !sclk_o && !line_oe_o && !valid_o && !busy_o, "R1",
        {cs_n_o, sclk_o, line_oe_o, valid_o, busy_o}, 16);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o && !sclk_o && !line_oe_o && !valid_o && !busy_o && !contention_o, "R1",
        {cs_n_o, sclk_o, line_oe_o, valid_o, busy_o}, 16);
  endtask

  task automatic t_frame(input logic sgl, input logic odd, input logic [W-1:0] val);
    start_frame(sgl, odd, val);
    finish_frame(sgl, odd, val, 1'b0);
  endtask

  task automatic t_r3_change_on_fall();
    int bad_chg = 0;
    logic pl = 1'b1, ps = 1'b0;
    start_frame(1'b1, 1'b0, 10'h0F0);
    repeat (4*2*H) begin
      @(negedge clk);
      if (line_oe_o && line_out_o != pl && !(ps && !sclk_o)) bad_chg++;
      pl = line_out_o; ps = sclk_o;
    end
    chk(bad_chg == 0, "R3", bad_chg, 0);
    finish_frame(1'b1, 1'b0, 10'h0F0, 1'b0);
  endtask

  task automatic t_r9_contention();
    int n = 0;
    start_frame(1'b0, 1'b1, 10'h2A5);
    while (rises < 2 && n < 100) begin @(negedge clk); n++; end
    force_drive = 1'b1;
    @(negedge clk);
    force_drive = 1'b0;
    chk(contention_o == 1'b1, "R9", contention_o, 1);
    @(negedge clk);
    chk(contention_o == 1'b0, "R9", contention_o, 0);
    finish_frame(1'b0, 1'b1, 10'h2A5, 1'b1);
  endtask

  task automatic t_r10_busy_req();
    start_frame(1'b1, 1'b1, 10'h3C3);
    repeat (9) @(negedge clk);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    finish_frame(1'b1, 1'b1, 10'h3C3, 1'b0);
    repeat (5) @(negedge clk);
    chk(cs_n_o && !busy_o, "R10", {cs_n_o, busy_o}, 2);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_mon();
    t_reset();
    t_frame(1'b1, 1'b0, 10'h3FF);
    t_frame(1'b0, 1'b0, 10'h000);
    t_frame(1'b1, 1'b1, 10'h201);
    t_frame(1'b0, 1'b1, 10'h155);
    t_r3_change_on_fall();
    t_r9_contention();
    t_r10_busy_req();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule